// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Unit

This unit holds two stack pointers, one used while the processor runs normally and one used while it services an exception. Each cycle the exception-mode flag picks which of the two a stack operation works on. It handles three kinds of stack operation:

- **Push**: emits the current pointer as the address, then advances the pointer by the access size.
- **Pop**: retreats the pointer by the access size first, then emits the new value.
- **Offset access**: adds a signed 16-bit immediate to the pointer to reach any slot, and leaves the pointer as it was.

Software can also load either pointer directly through a write port. Both pointers are always visible on the outputs.

The address for an operation is registered and appears on the cycle after the operation is presented, together with a valid strobe. A two-state machine records which pointer produced the last address:

- **BK_NORMAL** moves to **BK_EXCEPT** on transition ENTER_EXC, which is any stack operation taken with the mode flag high.
- **BK_EXCEPT** returns to **BK_NORMAL** on transition LEAVE_EXC, which is any stack operation taken with the flag low.
- Idle cycles hold the state.

The state drives the bank output that travels with the address. Memory and the sequencing of exception entry are outside this unit.

Top module: `sp_pair_unit`

## Requirements
- R1: During and right after reset, `nsp_o` equals parameter NSP_RST (default 32'h0000_1000), `esp_o` equals ESP_RST (default 32'h0000_2000), `ea_vld_o` is 0 and `ea_bank_o` is 0.
- R2: A push (`op_i`=2'b01) drives `ea_o` with the active pointer's value before the operation on the next cycle. In the same cycle that pointer becomes its old value plus 2**`size_i` bytes.
- R3: A pop (`op_i`=2'b10) makes the active pointer its old value minus 2**`size_i`. On the next cycle `ea_o` shows that decremented value.
- R4: An offset access (`op_i`=2'b11) drives `ea_o` on the next cycle with the active pointer plus `offset_i` sign-extended from 16 bits. No pointer changes.
- R5: `exc_mode_i`=1 selects the exception pointer and 0 selects the normal pointer. `ea_bank_o` is registered alongside `ea_o` and reports which pointer was used, with 1 meaning the exception pointer.
- R6: A stack operation never changes the pointer that `exc_mode_i` did not select.
- R7: With `wr_en_i`=1, the pointer named by `wr_sel_i` (0 normal, 1 exception) takes `wr_data_i` on the next cycle. This write overrides a push or pop update of the same pointer in that cycle. The address of that push or pop is still produced from the pointer's old value.
- R8: With `op_i`=2'b00 (idle) and no write, `ea_vld_o` is 0 on the next cycle and both pointers hold.
- R9: Pointer and address arithmetic wraps modulo 2**32. For example, a 1-byte pop from 0 yields 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Stack operation: 00 idle, 01 push, 10 pop, 11 offset access |
| exc_mode_i | input | 1 | 1 selects the exception pointer |
| size_i | input | 2 | Access size as log2 of bytes (1, 2, 4, 8) |
| offset_i | input | 16 | Signed immediate for offset access |
| wr_en_i | input | 1 | Direct pointer write enable |
| wr_sel_i | input | 1 | Write target: 0 normal, 1 exception |
| wr_data_i | input | 32 | Direct write value |
| ea_o | output | 32 | Effective address of the last operation |
| ea_vld_o | output | 1 | `ea_o` is valid this cycle |
| ea_bank_o | output | 1 | Pointer that produced `ea_o` (1 exception) |
| nsp_o | output | 32 | Normal-mode stack pointer |
| esp_o | output | 32 | Exception-mode stack pointer |

## Verification
Every result of an operation or write presented before a rising edge is due exactly one cycle later:

- the address, its valid strobe and its bank flag;
- both pointer values.

The bench drives inputs on the falling edge. It advances a behavioural model by one operation and compares all outputs on the following falling edge, which lies after the single register stage. Directed sequences cover a write colliding with a push, pops that wrap through zero, and negative offsets. A long stream of random operations follows them.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_PEEK = 2'b11
    } sp_op_e;

    typedef enum logic {
        BK_NORMAL = 1'b0,
        BK_EXCEPT = 1'b1
    } sp_bank_e;
endpackage

// File: rtl/sp_addr_calc.sv
module sp_addr_calc
    import sp_pkg::*;
#(
    parameter int PW = 32,
    parameter int OW = 16
) (
    input  logic [PW-1:0] ptr_i,
    input  sp_op_e        op_i,
    input  logic [1:0]    size_i,
    input  logic [OW-1:0] offset_i,
    output logic [PW-1:0] ea_o,
    output logic [PW-1:0] nxt_o,
    output logic          upd_o
);
    localparam int EXT = PW - OW;

    logic [PW-1:0] step;
    logic [PW-1:0] off_ext;
    logic [PW-1:0] dec_val;
    logic [PW-1:0] inc_val;

    assign step    = PW'(1) << size_i;
    assign off_ext = {{EXT{offset_i[OW-1]}}, offset_i};
    assign dec_val = ptr_i - step;
    assign inc_val = ptr_i + step;

    always_comb begin
        ea_o  = ptr_i;
        nxt_o = ptr_i;
        upd_o = 1'b0;
        unique case (op_i)
            OP_PUSH: begin
                ea_o  = ptr_i;
                nxt_o = inc_val;
                upd_o = 1'b1;
            end
            OP_POP: begin
                ea_o  = dec_val;
                nxt_o = dec_val;
                upd_o = 1'b1;
            end
            OP_PEEK: begin
                ea_o  = ptr_i + off_ext;
            end
            default: begin
                ea_o  = ptr_i;
            end
        endcase
    end
endmodule

// File: rtl/sp_bank_reg.sv
module sp_bank_reg #(
    parameter int          PW      = 32,
    parameter logic [PW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_data_i,
    input  logic          upd_en_i,
    input  logic [PW-1:0] upd_val_i,
    output logic [PW-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST_VAL;
        end else if (wr_en_i) begin
            q_o <= wr_data_i;
        end else if (upd_en_i) begin
            q_o <= upd_val_i;
        end
    end
endmodule

// File: rtl/sp_pair_unit.sv
module sp_pair_unit
    import sp_pkg::*;
#(
    parameter int            PW      = 32,
    parameter int            OW      = 16,
    parameter logic [PW-1:0] NSP_RST = 32'h0000_1000,
    parameter logic [PW-1:0] ESP_RST = 32'h0000_2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_i,
    input  logic          exc_mode_i,
    input  logic [1:0]    size_i,
    input  logic [OW-1:0] offset_i,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [PW-1:0] wr_data_i,
    output logic [PW-1:0] ea_o,
    output logic          ea_vld_o,
    output logic          ea_bank_o,
    output logic [PW-1:0] nsp_o,
    output logic [PW-1:0] esp_o
);
    localparam int NBANK = 2;

    sp_op_e        op;
    logic [PW-1:0] ptr_q [NBANK];
    logic [PW-1:0] act_ptr;
    logic [PW-1:0] calc_ea;
    logic [PW-1:0] calc_nxt;
    logic          calc_upd;
    sp_bank_e      state_q, state_d;
    logic [PW-1:0] ea_q;
    logic          vld_q;

    assign op      = sp_op_e'(op_i);
    assign act_ptr = exc_mode_i ? ptr_q[1] : ptr_q[0];

    sp_addr_calc #(.PW(PW), .OW(OW)) u_calc (
        .ptr_i    (act_ptr),
        .op_i     (op),
        .size_i   (size_i),
        .offset_i (offset_i),
        .ea_o     (calc_ea),
        .nxt_o    (calc_nxt),
        .upd_o    (calc_upd)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [PW-1:0] RV = (g == 0) ? NSP_RST : ESP_RST;
        sp_bank_reg #(.PW(PW), .RST_VAL(RV)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en_i && (wr_sel_i == 1'(g))),
            .wr_data_i (wr_data_i),
            .upd_en_i  (calc_upd && (exc_mode_i == 1'(g))),
            .upd_val_i (calc_nxt),
            .q_o       (ptr_q[g])
        );
    end

    // Bank-tracking state machine: ENTER_EXC / LEAVE_EXC on any stack operation
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_NORMAL: if (op != OP_IDLE && exc_mode_i)  state_d = BK_EXCEPT;
            BK_EXCEPT: if (op != OP_IDLE && !exc_mode_i) state_d = BK_NORMAL;
            default:   state_d = BK_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= (op != OP_IDLE);
            if (op != OP_IDLE) begin
                ea_q <= calc_ea;
            end
        end
    end

    assign ea_o      = ea_q;
    assign ea_vld_o  = vld_q;
    assign ea_bank_o = (state_q == BK_EXCEPT);
    assign nsp_o     = ptr_q[0];
    assign esp_o     = ptr_q[1];

    AST_RST_VALUES: assert property (@(posedge clk)
        $past(!rst_n) |-> (nsp_o == NSP_RST && esp_o == ESP_RST && !ea_vld_o)); // R1

    AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && !exc_mode_i) |=> (ea_o == $past(nsp_o))); // R2

    AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && exc_mode_i && !(wr_en_i && wr_sel_i)) |=> (ea_o == esp_o)); // R3

    AST_PEEK_KEEPS_NSP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PEEK && !exc_mode_i && !wr_en_i) |=> $stable(nsp_o)); // R4

    AST_BANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_IDLE) |=> (ea_bank_o == $past(exc_mode_i))); // R5

    AST_INACTIVE_ESP: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_IDLE && !exc_mode_i && !wr_en_i) |=> $stable(esp_o)); // R6

    AST_INACTIVE_NSP: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_IDLE && exc_mode_i && !wr_en_i) |=> $stable(nsp_o)); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (nsp_o == $past(wr_data_i))); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE && !wr_en_i) |=> (!ea_vld_o && $stable(nsp_o) && $stable(esp_o))); // R8
endmodule

// File: tb/sim_sp_pair_unit.sv
module sim_sp_pair_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NRST = 32'h0000_1000;
    localparam logic [31:0] ERST = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_i;
    logic        exc_mode_i;
    logic [1:0]  size_i;
    logic [15:0] offset_i;
    logic        wr_en_i;
    logic        wr_sel_i;
    logic [31:0] wr_data_i;
    logic [31:0] ea_o;
    logic        ea_vld_o;
    logic        ea_bank_o;
    logic [31:0] nsp_o;
    logic [31:0] esp_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_nsp, m_esp, m_ea;
    logic        m_vld, m_bank;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_pair_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .exc_mode_i(exc_mode_i),
        .size_i(size_i), .offset_i(offset_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ea_o(ea_o),
        .ea_vld_o(ea_vld_o), .ea_bank_o(ea_bank_o), .nsp_o(nsp_o), .esp_o(esp_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One operation: drive at negedge, advance model, compare at next negedge.
    task automatic step(input logic [1:0] op, input logic exc, input logic [1:0] sz,
                        input logic [15:0] off, input logic we, input logic ws,
                        input logic [31:0] wd, input string force_tag);
        logic [31:0] ptr, nxt, stp;
        string optag, ntag, etag;
        op_i = op; exc_mode_i = exc; size_i = sz; offset_i = off;
        wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
        ptr = exc ? m_esp : m_nsp;
        stp = 32'd1 << sz;
        nxt = ptr;
        case (op)
            2'b01: begin m_ea = ptr;       nxt = ptr + stp; optag = "R2"; end
            2'b10: begin m_ea = ptr - stp; nxt = ptr - stp; optag = "R3"; end
            2'b11: begin m_ea = ptr + {{16{off[15]}}, off}; optag = "R4"; end
            default: optag = "R8";
        endcase
        m_vld = (op != 2'b00);
        if (m_vld) m_bank = exc;
        if (exc) m_esp = nxt; else m_nsp = nxt;
        if (we) begin
            if (ws) m_esp = wd; else m_nsp = wd;
        end
        ntag = (we && !ws) ? "R7" : (m_vld && !exc) ? optag : m_vld ? "R6" : "R8";
        etag = (we && ws)  ? "R7" : (m_vld && exc)  ? optag : m_vld ? "R6" : "R8";
        if (force_tag != "") begin optag = force_tag; ntag = force_tag; etag = force_tag; end
        @(negedge clk);
        chk(optag, "ea_vld", {31'd0, ea_vld_o}, {31'd0, m_vld});
        if (m_vld) begin
            chk(optag, "ea", ea_o, m_ea);
            chk("R5", "ea_bank", {31'd0, ea_bank_o}, {31'd0, m_bank});
        end
        chk(ntag, "nsp", nsp_o, m_nsp);
        chk(etag, "esp", esp_o, m_esp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_i = 2'b00; exc_mode_i = 1'b0; size_i = 2'b00;
        offset_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        m_nsp = NRST; m_esp = ERST; m_ea = '0; m_vld = 1'b0; m_bank = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "nsp", nsp_o, NRST);
        chk("R1", "esp", esp_o, ERST);
        chk("R1", "ea_vld", {31'd0, ea_vld_o}, 32'd0);
        chk("R1", "ea_bank", {31'd0, ea_bank_o}, 32'd0);
        rst_n = 1'b1;
        // R2 push on both banks
        step(2'b01, 1'b0, 2'd2, 16'h0, 1'b0, 1'b0, '0, "");
        step(2'b01, 1'b1, 2'd3, 16'h0, 1'b0, 1'b0, '0, "");
        // R3 pops
        step(2'b10, 1'b0, 2'd2, 16'h0, 1'b0, 1'b0, '0, "");
        step(2'b10, 1'b1, 2'd0, 16'h0, 1'b0, 1'b0, '0, "");
        // R4 offset access, positive and negative
        step(2'b11, 1'b0, 2'd0, 16'h0010, 1'b0, 1'b0, '0, "");
        step(2'b11, 1'b1, 2'd0, 16'hFFF0, 1'b0, 1'b0, '0, "");
        // R8 idle
        step(2'b00, 1'b1, 2'd1, 16'h0, 1'b0, 1'b0, '0, "");
        // R7 write collides with push on same pointer
        step(2'b01, 1'b0, 2'd2, 16'h0, 1'b1, 1'b0, 32'h0000_8000, "");
        // R7 write to inactive pointer during pop
        step(2'b10, 1'b0, 2'd1, 16'h0, 1'b1, 1'b1, 32'h0000_4000, "");
        // R9 wrap through zero and at the top
        step(2'b00, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 32'h0000_0000, "R7");
        step(2'b10, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, '0, "R9");
        chk("R9", "nsp after wrap", nsp_o, 32'hFFFF_FFFF);
        step(2'b01, 1'b0, 2'd3, 16'h0, 1'b0, 1'b0, '0, "R9");
        chk("R9", "nsp after top wrap", nsp_o, 32'h0000_0007);
        step(2'b11, 1'b0, 2'd0, 16'h8000, 1'b0, 1'b0, '0, "R9");
        // random stream
        for (int k = 0; k < 4000; k++) begin
            logic we;
            we = ($urandom_range(0, 7) == 0);
            step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), 16'($urandom), we,
                 1'($urandom_range(0, 1)), $urandom, "");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule